// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block makes a pulse-width-modulated waveform that dims a display backlight. A reference clock first goes through an 8-bit prescaler. Each prescaler tick then advances a 16-bit period counter, which wraps after `scale + 1` ticks. The output is at its active level while the period counter is below the duty value. An invert bit chooses which logic level counts as active. An enable bit starts the waveform or parks it at the inactive level.

Software programs the block through a byte-wide write port. The 16-bit quantities are split into a low byte and a high byte. Prescaler, scale and duty writes go into shadow registers. The waveform picks up shadow values only when a period ends, or at once while the block is disabled, so a multi-byte update never produces a mixed period.

The waveform shares a general-purpose pin with ordinary GPIO. A 2-bit mux field decides whether the pin carries the PWM or the GPIO signals. The pin is never driven while the block is in reset.

Top module: `bklt_pwm`

## Requirements
- R1: Write address map, relative to base 0xA0: +0 prescaler (8 bits); +1 and +2 scale low and high byte; +3 and +4 duty low and high byte; +5 control, with bit 0 = invert and bit 1 = enable. Writes to other addresses change nothing.
- R2: While enabled, the output repeats with a period of max(pre,1) × (scale+1) reference-clock cycles.
- R3: Each period starts with the active level for max(pre,1) × min(duty,scale) cycles, followed by the inactive level for the rest of the period.
- R4: A prescaler value of 0 behaves exactly like a value of 1.
- R5: A duty value greater than scale behaves as if it equalled scale, so the output is active for scale out of scale+1 counts.
- R6: While disabled, the output rests at the inactive level: 0 when invert is 0 and 1 when invert is 1. The active level is always the opposite of the inactive level.
- R7: While disabled, the counters are held at zero. The first cycle after the enable write is the first cycle of a fresh period.
- R8: Prescaler, scale and duty writes made while enabled take effect only at the next period boundary. While disabled, they take effect immediately.
- R9: `pin_oe` is 0 while `rst_n` is low and for one further clock cycle after reset is released. The reset is applied asynchronously and released synchronously.
- R10: With `pin_mux_sel` equal to 2'b10, the pin carries the PWM output and `pin_oe` is 1. For any other value, `pin_out` and `pin_oe` follow `gpio_out` and `gpio_oe`.
- R11: Reset clears every register to zero, so after reset the block is disabled with invert 0 and its output is 0. Enabling it with no further writes gives a constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| pin_mux_sel | input | 2 | Function select for the shared pin (2'b10 = PWM) |
| gpio_out | input | 1 | GPIO output value for the shared pin |
| gpio_oe | input | 1 | GPIO output enable for the shared pin |
| pin_out | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Output enable of the shared pin |

## Verification
The hardest case to reach from the ports is a multi-byte reprogramming that lands in the middle of an enabled period, where the bench must see the old period run to its exact last cycle and the new one begin on the next. The stimulus sets up a slow period (prescaler 2, twenty cycles), enables it, and issues all five byte writes in its first few cycles. It then compares the pin on every cycle across the boundary against both configurations. A second hard spot is a scale that uses its high byte: one directed case runs a 257-count period with a prescaler of 1 and checks it cycle by cycle over two periods. Random configurations with zero prescaler, zero scale, and duty above scale cover the remaining clamps.

// File: rtl/bklt_pwm_pkg.sv
package bklt_pwm_pkg;
  // Mux field code that routes the PWM onto the shared pin
  localparam int unsigned MUX_W   = 2;
  localparam logic [1:0]  MUX_PWM = 2'b10;
  // Control byte bit positions
  localparam int unsigned CTRL_INV_BIT = 0;
  localparam int unsigned CTRL_EN_BIT  = 1;
endpackage

// File: rtl/bklt_pwm_regs.sv
module bklt_pwm_regs
  import bklt_pwm_pkg::*;
#(
  parameter logic [7:0]  BASE_ADDR = 8'hA0,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             wrap_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] scale_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             en_o,
  output logic             inv_o
);
  localparam int unsigned LANES     = (CNT_W + 7) / 8;
  localparam int unsigned SW        = LANES * 8;
  localparam int unsigned SCALE_OFS = 1;
  localparam int unsigned DUTY_OFS  = 1 + LANES;
  localparam int unsigned CTRL_OFS  = 1 + 2 * LANES;

  logic [PRE_W-1:0] pre_sh_q, pre_sh_d;
  logic [SW-1:0]    scale_sh_q, scale_sh_d;
  logic [SW-1:0]    duty_sh_q, duty_sh_d;
  logic             en_q, en_d, inv_q, inv_d;
  logic [PRE_W-1:0] pre_act_q;
  logic [CNT_W-1:0] scale_act_q, duty_act_q;
  logic [7:0]       ofs;
  logic             load;

  // Next-state decode of the byte write port
  always_comb begin
    ofs        = wr_addr - BASE_ADDR;
    pre_sh_d   = pre_sh_q;
    scale_sh_d = scale_sh_q;
    duty_sh_d  = duty_sh_q;
    en_d       = en_q;
    inv_d      = inv_q;
    if (ofs == 8'd0) pre_sh_d = wr_data[PRE_W-1:0];
    if (ofs == 8'(CTRL_OFS)) begin
      inv_d = wr_data[CTRL_INV_BIT];
      en_d  = wr_data[CTRL_EN_BIT];
    end
    for (int b = 0; b < LANES; b++) begin
      if (ofs == 8'(SCALE_OFS + b)) scale_sh_d[b*8 +: 8] = wr_data;
      if (ofs == 8'(DUTY_OFS + b))  duty_sh_d[b*8 +: 8]  = wr_data;
    end
    // Active bank follows the shadow while idle, else only at a wrap
    load = !en_q || wrap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sh_q   <= '0;
      scale_sh_q <= '0;
      duty_sh_q  <= '0;
      en_q       <= 1'b0;
      inv_q      <= 1'b0;
    end else if (wr_en) begin
      pre_sh_q   <= pre_sh_d;
      scale_sh_q <= scale_sh_d;
      duty_sh_q  <= duty_sh_d;
      en_q       <= en_d;
      inv_q      <= inv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_act_q   <= '0;
      scale_act_q <= '0;
      duty_act_q  <= '0;
    end else if (load) begin
      pre_act_q   <= pre_sh_q;
      scale_act_q <= scale_sh_q[CNT_W-1:0];
      duty_act_q  <= duty_sh_q[CNT_W-1:0];
    end
  end

  assign pre_o   = pre_act_q;
  assign scale_o = scale_act_q;
  assign duty_o  = duty_act_q;
  assign en_o    = en_q;
  assign inv_o   = inv_q;
endmodule

// File: rtl/bklt_pwm_core.sv
module bklt_pwm_core #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] scale_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PRE_W-1:0] pc_q, pc_d, pre_last;
  logic [CNT_W-1:0] cnt_q, cnt_d, duty_lim;
  logic             tick, at_end, level;

  always_comb begin
    // Prescaler of zero counts as one
    pre_last = (pre_i == '0) ? '0 : pre_i - PRE_W'(1);
    tick     = (pc_q == pre_last);
    at_end   = (cnt_q == scale_i);
    wrap_o   = en_i && tick && at_end;
    if (!en_i) begin
      pc_d  = '0;
      cnt_d = '0;
    end else begin
      pc_d  = tick ? '0 : pc_q + PRE_W'(1);
      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    end
    duty_lim = (duty_i > scale_i) ? scale_i : duty_i;
    level    = en_i && (cnt_q < duty_lim);
    pwm_o    = level ^ inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bklt_pwm_pinmux.sv
module bklt_pwm_pinmux
  import bklt_pwm_pkg::*;
(
  input  logic             rst_ok,
  input  logic [MUX_W-1:0] sel_i,
  input  logic             gpio_out_i,
  input  logic             gpio_oe_i,
  input  logic             pwm_i,
  output logic             pin_out_o,
  output logic             pin_oe_o
);
  logic pwm_sel;

  always_comb begin
    pwm_sel   = (sel_i == MUX_PWM);
    pin_out_o = pwm_sel ? pwm_i : gpio_out_i;
    pin_oe_o  = rst_ok && (pwm_sel || gpio_oe_i);
  end
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
  import bklt_pwm_pkg::*;
#(
  parameter logic [7:0]  BASE_ADDR = 8'hA0,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned CNT_W     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] pin_mux_sel,
  input  logic       gpio_out,
  input  logic       gpio_oe,
  output logic       pin_out,
  output logic       pin_oe
);
  logic             rst_meta, rst_q;
  logic             ctl_en, ctl_inv, pwm_raw, per_wrap;
  logic [PRE_W-1:0] act_pre;
  logic [CNT_W-1:0] act_scale, act_duty, per_cnt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bklt_pwm_regs #(.BASE_ADDR(BASE_ADDR), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap_i(per_wrap), .pre_o(act_pre), .scale_o(act_scale), .duty_o(act_duty),
    .en_o(ctl_en), .inv_o(ctl_inv)
  );

  bklt_pwm_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_q), .en_i(ctl_en), .inv_i(ctl_inv), .pre_i(act_pre),
    .scale_i(act_scale), .duty_i(act_duty), .pwm_o(pwm_raw), .wrap_o(per_wrap),
    .cnt_o(per_cnt)
  );

  bklt_pwm_pinmux u_mux (
    .rst_ok(rst_q), .sel_i(pin_mux_sel), .gpio_out_i(gpio_out), .gpio_oe_i(gpio_oe),
    .pwm_i(pwm_raw), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk
  import bklt_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             en,
  input logic             inv,
  input logic             pwm,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] scale,
  input logic [CNT_W-1:0] duty,
  input logic [1:0]       sel,
  input logic             pin_oe
);
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_ok)
    !en |-> pwm == inv);

  a_r7_counter_held: assert property (@(posedge clk) disable iff (!rst_ok)
    !en |=> cnt == '0);

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_ok)
    en |-> cnt <= scale);

  a_r5_duty_clamp: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && (pwm != inv)) |-> cnt < scale);

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && !wrap) |=> ($stable(scale) && $stable(duty)));

  a_r9_no_drive_in_reset: assert property (@(posedge clk)
    !rst_ok |-> !pin_oe);

  a_r10_pwm_owns_pin: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel == MUX_PWM) |-> pin_oe);
endmodule

bind bklt_pwm bklt_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_ok(rst_q), .en(ctl_en), .inv(ctl_inv), .pwm(pwm_raw),
  .wrap(per_wrap), .cnt(per_cnt), .scale(act_scale), .duty(act_duty),
  .sel(pin_mux_sel), .pin_oe(pin_oe)
);

// File: tb/bklt_pwm_test.sv
`timescale 1ns/1ps
module bklt_pwm_test;
  logic       clk, rst_n, wr_en, gpio_out, gpio_oe, pin_out, pin_oe;
  logic [7:0] wr_addr, wr_data;
  logic [1:0] pin_mux_sel;
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  localparam logic [7:0] A_PRE = 8'hA0, A_SLO = 8'hA1, A_SHI = 8'hA2,
                         A_DLO = 8'hA3, A_DHI = 8'hA4, A_CTL = 8'hA5;

  bklt_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_mux_sel(pin_mux_sel), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic got, logic exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Expected pin level k cycles after the enabling write (R2, R3, R4, R5)
  function automatic logic exp_level(int k, int pre, int scale, int duty, logic inv);
    int pe, pos, dc;
    pe  = (pre == 0) ? 1 : pre;
    pos = (k / pe) % (scale + 1);
    dc  = (duty > scale) ? scale : duty;
    return logic'(pos < dc) ^ inv;
  endfunction

  task automatic load_cfg(int pre, int scale, int duty, logic inv);
    wr(A_CTL, {6'b0, 1'b0, inv});
    wr(A_PRE, pre[7:0]);
    wr(A_SLO, scale[7:0]);
    wr(A_SHI, scale[15:8]);
    wr(A_DLO, duty[7:0]);
    wr(A_DHI, duty[15:8]);
  endtask

  task automatic run_cfg(string tag, int pre, int scale, int duty, logic inv);
    int p;
    load_cfg(pre, scale, duty, inv);
    for (int i = 0; i < 3; i++) begin
      chk($sformatf("R6 idle %s", tag), pin_out, inv);
      @(negedge clk);
    end
    wr(A_CTL, {6'b0, 1'b1, inv});
    p = ((pre == 0) ? 1 : pre) * (scale + 1);
    for (int k = 0; k < 2 * p; k++) begin
      chk($sformatf("%s k=%0d", tag, k), pin_out, exp_level(k, pre, scale, duty, inv));
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual hung expected finished run");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int seed_unused;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pin_mux_sel = 2'b10; gpio_out = 1'b1; gpio_oe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 oe in reset", pin_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 oe during sync release", pin_oe, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 oe after reset", pin_oe, 1'b1);
    chk("R11 idle low after reset", pin_out, 1'b0);
    wr(A_CTL, 8'h02);
    for (int i = 0; i < 6; i++) begin
      chk("R11 enabled with reset config", pin_out, 1'b0);
      @(negedge clk);
    end
    wr(A_CTL, 8'h00);

    // Directed corners
    run_cfg("R5 duty above scale", 1, 3, 16'hFFFF, 1'b0);
    run_cfg("R5 duty eq scale+1", 2, 4, 5, 1'b0);
    run_cfg("R4 prescaler zero", 0, 4, 2, 1'b0);
    run_cfg("R6 inverted R2", 3, 5, 2, 1'b1);
    run_cfg("R1 high bytes R3", 1, 16'h0100, 16'h0080, 1'b0);
    run_cfg("R3 duty zero", 2, 6, 0, 1'b0);
    run_cfg("R2 scale zero", 1, 0, 0, 1'b1);

    // R8: reprogram mid-period while enabled
    load_cfg(2, 9, 3, 1'b0);
    wr(A_CTL, 8'h02);
    wr(A_PRE, 8'd1); wr(A_SLO, 8'd4); wr(A_SHI, 8'd0); wr(A_DLO, 8'd2); wr(A_DHI, 8'd0);
    for (int k = 5; k < 40; k++) begin
      chk($sformatf("R8 shadow k=%0d", k), pin_out,
          (k < 20) ? exp_level(k, 2, 9, 3, 1'b0) : exp_level(k - 20, 1, 4, 2, 1'b0));
      @(negedge clk);
    end
    // R1: a write outside the map leaves the waveform unchanged
    wr(8'hA6, 8'hFF);
    wr(8'h9F, 8'hFF);
    run_cfg("R1 after stray writes R7", 1, 4, 2, 1'b0);

    // Constrained random configurations
    seed_unused = $urandom(32'd4242);
    for (int n = 0; n < 14; n++) begin
      int pre, scale, duty;
      logic inv;
      pre   = $urandom_range(0, 5);
      scale = $urandom_range(0, 12);
      duty  = $urandom_range(0, 15);
      inv   = logic'($urandom_range(0, 1));
      run_cfg($sformatf("R3 random %0d", n), pre, scale, duty, inv);
    end

    // R10: pin mux
    wr(A_CTL, 8'h00);
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        pin_mux_sel = 2'(s); gpio_out = 1'b1; gpio_oe = 1'b0;
        #1;
        chk("R10 gpio out", pin_out, 1'b1);
        chk("R10 gpio oe", pin_oe, 1'b0);
        gpio_out = 1'b0; gpio_oe = 1'b1;
        #1;
        chk("R10 gpio out low", pin_out, 1'b0);
        chk("R10 gpio oe high", pin_oe, 1'b1);
        @(negedge clk);
      end
    end
    pin_mux_sel = 2'b10; gpio_out = 1'b0; gpio_oe = 1'b0;
    #1;
    chk("R10 pwm oe", pin_oe, 1'b1);
    chk("R10 pwm idle", pin_out, 1'b0);
    @(negedge clk);
    wr(A_CTL, 8'h01);
    chk("R10 R6 pwm idle inverted", pin_out, 1'b1);
    pin_mux_sel = 2'b00; gpio_out = 1'b0;
    #1;
    chk("R10 gpio over inverted pwm", pin_out, 1'b0);
    pin_mux_sel = 2'b10;
    @(negedge clk);

    // R9/R11: reset in the middle of an enabled waveform
    load_cfg(1, 3, 2, 1'b0);
    wr(A_CTL, 8'h02);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 oe on async reset", pin_oe, 1'b0);
    @(negedge clk);
    chk("R9 oe held in reset", pin_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 oe sync release", pin_oe, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 oe back", pin_oe, 1'b1);
    for (int i = 0; i < 5; i++) begin
      chk("R11 disabled after reset", pin_out, 1'b0);
      @(negedge clk);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule